// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small processor core. Every instruction it runs is fetched, decoded, executed and retired within one clock cycle. It handles five register-to-register operations: add, subtract, and, or, and signed set-less-than. It also handles word load, word store, and branch-if-equal. All of these share one datapath. The program counter, the register file, the ALU and the sign extender are each used at most once per cycle. Instructions and data live in two separate internal word arrays, so a fetch and a data access can happen in the same cycle.

A test environment or a boot agent fills both arrays through a word-wide load port, normally while reset is held. It then releases reset and watches the core run. The core makes its work visible on a retire-side trace: the current program counter, the effective register write (enable, register number, value), and the data-memory write (enable, byte address, value). Clock and an active-low synchronous reset are the only system inputs.

Instruction fields: opcode in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11, function code in 5:0, and the 16-bit immediate in 15:0.

Top module: `onecycle_core`

## Requirements
- R1: While `rst_n` is low, the program counter becomes 0 at the next clock edge, all 32 registers become 0, and no register or data-memory write is reported.
- R2: Any instruction other than a taken branch-if-equal advances the program counter by exactly 4 at the next rising edge.
- R3: Opcode 0x00 with function code 0x20 (add), 0x22 (sub), 0x24 (and), 0x25 (or) or 0x2A (signed set-less-than, result 1 or 0) writes rs op rt into register rd.
- R4: Register 0 always reads as zero. A write aimed at it is dropped, and no write is reported on the trace.
- R5: Opcode 0x23 (load word) reads the data word at byte address rs + sign-extended immediate and writes it into register rt.
- R6: Opcode 0x2B (store word) writes register rt to the data word at byte address rs + sign-extended immediate, and writes no register.
- R7: Opcode 0x04 (branch-if-equal) compares rs and rt by subtraction. When they are equal, the next program counter is PC + 4 + (sign-extended immediate << 2); otherwise it is PC + 4. It writes no register and no memory.
- R8: An undefined opcode, or an undefined function code under opcode 0x00, acts as a no-op: no register write, no memory write, and the program counter advances by 4.
- R9: The immediate is widened by copying bit 15 into all upper bits, so a negative offset lowers the address.
- R10: With `ld_we` high, `ld_data` is written at the next rising edge into word `ld_addr` of the data array when `ld_dmem` is 1, or of the instruction array when it is 0. Word n of the instruction array holds the instruction at byte address 4n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_we | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load-port target: 1 data array, 0 instruction array |
| ld_addr | input | LDW (6) | Load-port word index |
| ld_data | input | XLEN (32) | Load-port write word |
| pc_o | output | XLEN (32) | Byte address of the instruction in execution |
| rf_we_o | output | 1 | A register is written at the coming edge |
| rf_waddr_o | output | 5 | Register number being written |
| rf_wdata_o | output | XLEN (32) | Value being written to the register |
| dm_we_o | output | 1 | Data memory is written at the coming edge |
| dm_addr_o | output | XLEN (32) | Byte address of the data access |
| dm_wdata_o | output | XLEN (32) | Store value |

## Verification
The bench builds the core with its default 32-bit words and 64-word instruction and data arrays. This is enough room for a program that covers every opcode and function code, taken and not-taken branches, a forward skip, a self-loop and a negative store offset. A reset in the middle of a run shows that registers clear while data memory keeps its stores. Because of that, the replay reaches a different store address.

// File: rtl/core_pkg.sv
// Package core_pkg: shared encodings and the decoded control word.
// Assumes 6-bit opcodes and 6-bit function codes in the usual field spots.
package core_pkg;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_LDW  = 6'h23;
    localparam logic [5:0] OPC_STW  = 6'h2B;
    localparam logic [5:0] OPC_BEQ  = 6'h04;

    localparam logic [5:0] FN_ADD   = 6'h20;
    localparam logic [5:0] FN_SUB   = 6'h22;
    localparam logic [5:0] FN_AND   = 6'h24;
    localparam logic [5:0] FN_OR    = 6'h25;
    localparam logic [5:0] FN_SLT   = 6'h2A;

    typedef struct packed {
        logic    reg_write;
        logic    dst_is_rd;
        logic    mem_read;
        logic    mem_write;
        logic    wb_from_mem;
        logic    b_from_imm;
        logic    is_branch;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/core_decode.sv
// Module core_decode: the main decoder and the ALU-operation decoder merged
// into one combinational table. Any opcode or function code not listed
// yields an all-inactive control word, which makes it a no-op.
module core_decode
    import core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    // Map opcode/function pairs onto datapath controls.
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (opcode)
            OPC_REG: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_write = 1'b1;
                case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_write = 1'b0;
                endcase
            end
            OPC_LDW: begin
                ctrl.reg_write   = 1'b1;
                ctrl.mem_read    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.b_from_imm  = 1'b1;
            end
            OPC_STW: begin
                ctrl.mem_write  = 1'b1;
                ctrl.b_from_imm = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/core_alu.sv
// Module core_alu: combinational arithmetic/logic unit with a zero flag.
// Assumes the select values from core_pkg; set-less-than compares signed.
module core_alu
    import core_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    // Select the operation result.
    always_comb begin
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/core_regfile.sv
// Module core_regfile: NREGS x XLEN registers, two combinational read ports,
// one write port taken at the rising edge. Entry 0 is hard-wired to zero.
// Assumes reset clears every entry.
module core_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int RAW  = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RAW-1:0]  waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RAW-1:0]  raddr_a,
    input  logic [RAW-1:0]  raddr_b,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b
);

    logic [XLEN-1:0] regs [NREGS];

    // Clear on reset, else commit the single write unless it targets entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

endmodule

// File: rtl/core_wordmem.sv
// Module core_wordmem: DEPTH x XLEN word array, written at the rising edge
// and read combinationally. Contents are not reset.
module core_wordmem #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr,
    output logic [XLEN-1:0] rdata
);

    logic [XLEN-1:0] words [DEPTH];

    // Store one word per write strobe.
    always_ff @(posedge clk) begin
        if (we) words[waddr] <= wdata;
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/onecycle_core.sv
// Module onecycle_core: single-cycle core. Fetch, decode, register read,
// ALU, data access and write-back all settle inside one clock period.
// Assumes word-aligned PCs and data addresses (the low two address bits
// are dropped) and that the load port is used while the core is held in
// reset; a load-port data write takes priority over a store.
module onecycle_core
    import core_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 64,
    localparam int IAW       = $clog2(IMEM_DEPTH),
    localparam int DAW       = $clog2(DMEM_DEPTH),
    localparam int LDW       = (IAW > DAW) ? IAW : DAW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_we,
    input  logic            ld_dmem,
    input  logic [LDW-1:0]  ld_addr,
    input  logic [XLEN-1:0] ld_data,
    output logic [XLEN-1:0] pc_o,
    output logic            rf_we_o,
    output logic [4:0]      rf_waddr_o,
    output logic [XLEN-1:0] rf_wdata_o,
    output logic            dm_we_o,
    output logic [XLEN-1:0] dm_addr_o,
    output logic [XLEN-1:0] dm_wdata_o
);

    logic [XLEN-1:0] pc, pc_plus4, br_target, pc_next;
    logic [31:0]     instr;
    ctrl_t           ctrl;
    logic [XLEN-1:0] rd1, rd2, imm_ext, alu_b, alu_y, dm_rdata, wb_data;
    logic            alu_zero;
    logic [4:0]      waddr;
    logic            rf_we, core_dm_we;
    logic            dmem_we;
    logic [DAW-1:0]  dmem_waddr;
    logic [XLEN-1:0] dmem_wdata;
    logic            unused_bits;

    // Instruction array: written only by the load port.
    core_wordmem #(.XLEN(32), .DEPTH(IMEM_DEPTH)) u_imem (
        .clk   (clk),
        .we    (ld_we && !ld_dmem),
        .waddr (ld_addr[IAW-1:0]),
        .wdata (ld_data[31:0]),
        .raddr (pc[IAW+1:2]),
        .rdata (instr)
    );

    core_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    assign waddr = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
    assign rf_we = ctrl.reg_write && rst_n;

    core_regfile #(.XLEN(XLEN), .NREGS(32)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (waddr),
        .wdata   (wb_data),
        .raddr_a (instr[25:21]),
        .raddr_b (instr[20:16]),
        .rdata_a (rd1),
        .rdata_b (rd2)
    );

    assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign alu_b   = ctrl.b_from_imm ? imm_ext : rd2;

    core_alu #(.XLEN(XLEN)) u_alu (
        .a    (rd1),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign core_dm_we = ctrl.mem_write && rst_n;
    assign dmem_we    = (ld_we && ld_dmem) || core_dm_we;
    assign dmem_waddr = (ld_we && ld_dmem) ? ld_addr[DAW-1:0] : alu_y[DAW+1:2];
    assign dmem_wdata = (ld_we && ld_dmem) ? ld_data : rd2;

    // Data array: stores from the core, preload from the load port.
    core_wordmem #(.XLEN(XLEN), .DEPTH(DMEM_DEPTH)) u_dmem (
        .clk   (clk),
        .we    (dmem_we),
        .waddr (dmem_waddr),
        .wdata (dmem_wdata),
        .raddr (alu_y[DAW+1:2]),
        .rdata (dm_rdata)
    );

    assign wb_data   = ctrl.wb_from_mem ? dm_rdata : alu_y;
    assign pc_plus4  = pc + XLEN'(4);
    assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign pc_next   = (ctrl.is_branch && alu_zero) ? br_target : pc_plus4;

    // Program counter: cleared by reset, else takes the next address.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end

    assign pc_o       = pc;
    assign rf_we_o    = rf_we && (waddr != 5'd0);
    assign rf_waddr_o = waddr;
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = core_dm_we;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rd2;

    assign unused_bits = ^{instr[10:6], ctrl.mem_read, imm_ext[XLEN-1:XLEN-2]};

endmodule

// File: rtl/core_checker.sv
// Module core_checker: temporal checks on the core, bound to every
// onecycle_core instance. Observes the fetched word, the trace outputs,
// the first register read port and the ALU zero flag.
module core_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc,
    input logic [31:0]     instr,
    input logic            rf_we,
    input logic            dm_we,
    input logic [4:0]      ra1,
    input logic [XLEN-1:0] rd1,
    input logic            zero
);

    logic [5:0]      op;
    logic            known_op;
    logic [XLEN-1:0] tgt;

    assign op       = instr[31:26];
    assign known_op = (op == 6'h00) || (op == 6'h23) || (op == 6'h2B) || (op == 6'h04);
    assign tgt      = pc + XLEN'(4) + {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};

    // R1: nothing is written while reset is held.
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_quiet_in_reset: assert (!rf_we && !dm_we)
                else $error("R1 write reported during reset");
        end
    end

    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (op != 6'h04) |=> (pc == $past(pc) + XLEN'(4)));

    a_r7_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 6'h04 && zero) |=> (pc == $past(tgt)));

    a_r4_zero_reg_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ra1 == 5'd0) |-> (rd1 == '0));

    a_r6_store_no_regwrite: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> !rf_we);

    a_r8_undefined_is_noop: assert property (@(posedge clk) disable iff (!rst_n)
        !known_op |-> (!rf_we && !dm_we));

endmodule

bind onecycle_core core_checker #(.XLEN(XLEN)) u_core_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .pc    (pc),
    .instr (instr),
    .rf_we (rf_we_o),
    .dm_we (dm_we_o),
    .ra1   (instr[25:21]),
    .rd1   (rd1),
    .zero  (alu_zero)
);

// File: tb/tb_onecycle_core.sv
`timescale 1ns/1ps
// Bench for onecycle_core: preloads a program, then runs a behavioural
// architectural model beside the core and compares the trace each cycle.
module tb_onecycle_core;

    localparam int XLEN = 32;
    localparam int DEP  = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ld_we = 1'b0;
    logic            ld_dmem = 1'b0;
    logic [5:0]      ld_addr = '0;
    logic [31:0]     ld_data = '0;
    logic [31:0]     pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]      rf_waddr_o;
    logic            rf_we_o, dm_we_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_imem [DEP];
    logic [31:0] m_dmem [DEP];
    logic [31:0] m_regs [32];
    logic [31:0] m_pc;

    always #2.5 clk = ~clk;

    onecycle_core dut (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    function automatic logic [31:0] rt_op(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] im_op(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: compare this cycle's trace, then advance the state.
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                check("R1 rf_we", 32'(rf_we_o), 32'd0);
                check("R1 dm_we", 32'(dm_we_o), 32'd0);
                m_pc = 0;
                for (int i = 0; i < 32; i++) m_regs[i] = 0;
            end else begin
                logic [31:0] ins, a, b, imm, res, nxt;
                logic [5:0]  op, fn;
                int rs, rt, rd;
                bit we, swe, ok;
                int wr;
                string tag;
                ins = m_imem[m_pc[7:2]];
                op = ins[31:26]; fn = ins[5:0];
                rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
                a = m_regs[rs]; b = m_regs[rt];
                imm = {{16{ins[15]}}, ins[15:0]};
                nxt = m_pc + 4; we = 0; swe = 0; res = 0; wr = 0; tag = "R8";
                check("R2/R7 pc", pc_o, m_pc);
                if (op == 6'h00) begin
                    ok = 1; tag = "R3";
                    case (fn)
                        6'h20: res = a + b;
                        6'h22: res = a - b;
                        6'h24: res = a & b;
                        6'h25: res = a | b;
                        6'h2A: res = ($signed(a) < $signed(b)) ? 1 : 0;
                        default: begin ok = 0; tag = "R8"; end
                    endcase
                    if (ok) begin
                        wr = rd; we = (rd != 0);
                        if (rd == 0) tag = "R4";
                    end
                end else if (op == 6'h23) begin
                    tag = "R5/R10"; wr = rt; we = (rt != 0);
                    res = m_dmem[((a + imm) >> 2) & 63];
                end else if (op == 6'h2B) begin
                    tag = "R6/R9"; swe = 1;
                end else if (op == 6'h04) begin
                    tag = "R7";
                    if (a == b) nxt = m_pc + 4 + (imm << 2);
                end
                check({tag, " rf_we"}, 32'(rf_we_o), 32'(we));
                if (we) begin
                    check({tag, " rf_waddr"}, 32'(rf_waddr_o), 32'(wr));
                    check({tag, " rf_wdata"}, rf_wdata_o, res);
                    m_regs[wr] = res;
                end
                check({tag, " dm_we"}, 32'(dm_we_o), 32'(swe));
                if (swe) begin
                    check({tag, " dm_addr"}, dm_addr_o, a + imm);
                    check({tag, " dm_wdata"}, dm_wdata_o, b);
                    m_dmem[((a + imm) >> 2) & 63] = b;
                end
                m_pc = nxt;
            end
        end
    end

    task automatic load_word(bit dsel, int idx, logic [31:0] w);
        @(posedge clk); #1;
        ld_we = 1; ld_dmem = dsel; ld_addr = 6'(idx); ld_data = w;
        if (dsel) m_dmem[idx] = w; else m_imem[idx] = w;
        @(posedge clk); #1;
        ld_we = 0;
    endtask

    initial begin
        logic [31:0] prog [21];
        prog[0]  = im_op(6'h23, 0, 1, 16'd0);
        prog[1]  = im_op(6'h23, 0, 2, 16'd4);
        prog[2]  = rt_op(1, 2, 3, 6'h20);
        prog[3]  = rt_op(1, 2, 4, 6'h22);
        prog[4]  = rt_op(1, 2, 5, 6'h24);
        prog[5]  = rt_op(1, 2, 6, 6'h25);
        prog[6]  = rt_op(2, 1, 7, 6'h2A);
        prog[7]  = rt_op(1, 2, 8, 6'h2A);
        prog[8]  = rt_op(1, 1, 0, 6'h20);
        prog[9]  = rt_op(0, 1, 9, 6'h20);
        prog[10] = im_op(6'h23, 0, 10, 16'd8);
        prog[11] = im_op(6'h2B, 10, 4, 16'hFFFC);
        prog[12] = im_op(6'h23, 0, 11, 16'd8);
        prog[13] = im_op(6'h04, 1, 9, 16'd2);
        prog[14] = rt_op(1, 1, 12, 6'h20);
        prog[15] = rt_op(1, 1, 13, 6'h20);
        prog[16] = im_op(6'h04, 1, 2, 16'd5);
        prog[17] = im_op(6'h3F, 1, 14, 16'd4);
        prog[18] = rt_op(1, 2, 15, 6'h21);
        prog[19] = rt_op(11, 12, 16, 6'h20);
        prog[20] = im_op(6'h04, 0, 0, 16'hFFFF);
        for (int i = 0; i < DEP; i++) begin
            m_imem[i] = 0; m_dmem[i] = 0;
        end
        repeat (2) @(posedge clk);
        for (int i = 0; i < DEP; i++) load_word(0, i, (i < 21) ? prog[i] : 32'h0);
        for (int i = 0; i < DEP; i++) begin
            logic [31:0] w;
            w = (i == 0) ? 32'd7 : (i == 1) ? 32'hFFFF_FFF0 : (i == 2) ? 32'd12 : 32'(i * 3);
            load_word(1, i, w);
        end
        @(posedge clk); #1;
        rst_n = 1;
        repeat (30) @(posedge clk);
        #1 rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        repeat (28) @(posedge clk);
        #1;
        check("R1 replay pc in loop", pc_o, 32'd80);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule